// File: doc/BRIEF.md
# ALU with Local Function Decoder

This block is the arithmetic and logic unit of a simple single-issue processor datapath, together with the small decoder that drives it. The main control supplies a 2-bit operation class. The decoder combines that class with the 6-bit function field of a register-type instruction and produces a 4-bit operation code. The ALU core applies that code to two operands and returns a result and a flag that marks an all-zero result.

The whole path from inputs to outputs is combinational. It settles within the cycle in which its inputs are presented. The operation code is also brought out as a port, so that its encoding can be seen at the block's edge. Shifts, overflow detection, multiply and divide are not part of this block.

Top module: `alu_unit`

## Requirements
- R1: Operation class 2'b00 selects add, whatever the function field holds: ctrl_o = 4'b0010 and result_o = a_i + b_i, modulo 2^32.
- R2: Operation class 2'b01 selects subtract, whatever the function field holds: ctrl_o = 4'b0110 and result_o = a_i - b_i, modulo 2^32.
- R3: Under class 2'b10, function 6'b100000 gives add (ctrl_o = 4'b0010) and function 6'b100010 gives subtract (ctrl_o = 4'b0110).
- R4: Under class 2'b10, function 6'b100100 gives bitwise AND (ctrl_o = 4'b0000) and function 6'b100101 gives bitwise OR (ctrl_o = 4'b0001).
- R5: Under class 2'b10, function 6'b100111 gives bitwise NOR (ctrl_o = 4'b1100), with result_o = ~(a_i | b_i).
- R6: Under class 2'b10, function 6'b101010 gives set-on-less-than (ctrl_o = 4'b0111). The operands are compared as two's-complement signed values. result_o[0] is 1 when a_i < b_i, and 0 otherwise. Bits 31:1 are always zero.
- R7: Under class 2'b10, any function value other than the six listed above selects add (ctrl_o = 4'b0010). Class 2'b11 also selects add, for every function value.
- R8: zero_o is 1 exactly when all 32 bits of result_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_class_i | input | 2 | Operation class from the main control |
| funct_i | input | 6 | Function field of the instruction |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| ctrl_o | output | 4 | Decoded ALU operation code |
| result_o | output | 32 | ALU result |
| zero_o | output | 1 | High when result_o is all zeros |

## Verification
The block holds no state, so any fault shows up at the ports in the same cycle as the stimulus that exposes it. A decoder fault shows on ctrl_o for a particular class and function pair. It usually also shows as a wrong result_o for the operand pair applied in that cycle. A core fault shows as a wrong result_o or zero_o, but only for operands that expose it. For that reason, every class and function pair is applied with several operand pairs. Targeted cases are added for equal operands, sign-differing comparisons and carries that wrap around.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned FUNCT_W = 6;
  localparam int unsigned CTRL_W  = 4;
  localparam int unsigned CLASS_W = 2;

  typedef enum logic [CTRL_W-1:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111,
    ALU_NOR = 4'b1100
  } alu_ctrl_e;

  typedef enum logic [CLASS_W-1:0] {
    CLS_MEM    = 2'b00,
    CLS_BRANCH = 2'b01,
    CLS_REG    = 2'b10,
    CLS_SPARE  = 2'b11
  } op_class_e;

  localparam logic [FUNCT_W-1:0] FN_ADD = 6'b100000;
  localparam logic [FUNCT_W-1:0] FN_SUB = 6'b100010;
  localparam logic [FUNCT_W-1:0] FN_AND = 6'b100100;
  localparam logic [FUNCT_W-1:0] FN_OR  = 6'b100101;
  localparam logic [FUNCT_W-1:0] FN_NOR = 6'b100111;
  localparam logic [FUNCT_W-1:0] FN_SLT = 6'b101010;
endpackage

// File: rtl/alu_func_decode.sv
module alu_func_decode
  import alu_pkg::*;
(
  input  logic [CLASS_W-1:0] op_class_i,
  input  logic [FUNCT_W-1:0] funct_i,
  output alu_ctrl_e          ctrl_o
);
  always_comb begin
    ctrl_o = ALU_ADD;
    unique case (op_class_e'(op_class_i))
      CLS_MEM:    ctrl_o = ALU_ADD;
      CLS_BRANCH: ctrl_o = ALU_SUB;
      CLS_REG: begin
        case (funct_i)
          FN_ADD:  ctrl_o = ALU_ADD;
          FN_SUB:  ctrl_o = ALU_SUB;
          FN_AND:  ctrl_o = ALU_AND;
          FN_OR:   ctrl_o = ALU_OR;
          FN_NOR:  ctrl_o = ALU_NOR;
          FN_SLT:  ctrl_o = ALU_SLT;
          default: ctrl_o = ALU_ADD; // unknown funct falls back to add
        endcase
      end
      default:    ctrl_o = ALU_ADD;
    endcase
  end

  // R7
  always_comb begin
    if (!$isunknown(op_class_i) && op_class_i == 2'b11)
      spare_class_add_chk: assert (ctrl_o == ALU_ADD);
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  alu_ctrl_e         ctrl_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] result_o,
  output logic              zero_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic              do_sub;
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W-1:0] sum;
  logic              lt_signed;

  // subtract and compare share one adder via inverted b and carry-in
  assign do_sub = (ctrl_i == ALU_SUB) || (ctrl_i == ALU_SLT);
  assign b_eff  = do_sub ? ~b_i : b_i;
  assign sum    = a_i + b_eff + {{(DATA_W-1){1'b0}}, do_sub};

  // signs differ: a is less iff a negative; else difference sign decides
  assign lt_signed = (a_i[MSB] != b_i[MSB]) ? a_i[MSB] : sum[MSB];

  always_comb begin
    unique case (ctrl_i)
      ALU_AND: result_o = a_i & b_i;
      ALU_OR:  result_o = a_i | b_i;
      ALU_NOR: result_o = ~(a_i | b_i);
      ALU_SLT: result_o = {{(DATA_W-1){1'b0}}, lt_signed};
      default: result_o = sum;
    endcase
  end

  assign zero_o = ~|result_o;

  // R6
  always_comb begin
    if (!$isunknown(ctrl_i) && ctrl_i == ALU_SLT)
      slt_upper_clear_chk: assert (result_o[MSB:1] == '0);
  end
endmodule

// File: rtl/alu_unit.sv
module alu_unit
  import alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [CLASS_W-1:0] op_class_i,
  input  logic [FUNCT_W-1:0] funct_i,
  input  logic [DATA_W-1:0]  a_i,
  input  logic [DATA_W-1:0]  b_i,
  output logic [CTRL_W-1:0]  ctrl_o,
  output logic [DATA_W-1:0]  result_o,
  output logic               zero_o
);
  alu_ctrl_e ctrl;

  alu_func_decode i_decode (
    .op_class_i (op_class_i),
    .funct_i    (funct_i),
    .ctrl_o     (ctrl)
  );

  alu_core #(.DATA_W(DATA_W)) i_core (
    .ctrl_i   (ctrl),
    .a_i      (a_i),
    .b_i      (b_i),
    .result_o (result_o),
    .zero_o   (zero_o)
  );

  assign ctrl_o = ctrl;

  always_comb begin
    if (!$isunknown({op_class_i, funct_i, a_i, b_i})) begin
      // R2 R8
      if (op_class_i == 2'b01)
        branch_eq_zero_chk: assert (zero_o == (a_i == b_i));
      // R4
      if (ctrl_o == 4'b0000)
        and_within_a_chk: assert ((result_o & ~a_i) == '0);
      // R4
      if (ctrl_o == 4'b0001)
        or_covers_a_chk: assert ((result_o & a_i) == a_i);
      // R5
      if (ctrl_o == 4'b1100)
        nor_disjoint_chk: assert ((result_o & (a_i | b_i)) == '0);
    end
  end
endmodule

// File: tb/test_alu_unit.sv
`timescale 1ns/1ps
module test_alu_unit;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]  op_class;
  logic [5:0]  funct;
  logic [31:0] a, b;
  logic [3:0]  ctrl;
  logic [31:0] result;
  logic        zero;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit finished = 0;

  alu_unit i_alu_unit (
    .op_class_i (op_class),
    .funct_i    (funct),
    .a_i        (a),
    .b_i        (b),
    .ctrl_o     (ctrl),
    .result_o   (result),
    .zero_o     (zero)
  );

  function automatic logic [3:0] ref_ctrl(input logic [1:0] c, input logic [5:0] f);
    if (c == 2'd0) return 4'd2;
    if (c == 2'd1) return 4'd6;
    if (c == 2'd3) return 4'd2;
    case (f)
      6'd32: return 4'd2;
      6'd34: return 4'd6;
      6'd36: return 4'd0;
      6'd37: return 4'd1;
      6'd39: return 4'd12;
      6'd42: return 4'd7;
      default: return 4'd2;
    endcase
  endfunction

  function automatic logic [31:0] ref_result(input logic [3:0] k, input logic [31:0] x, input logic [31:0] y);
    longint sx = longint'($signed(x));
    longint sy = longint'($signed(y));
    case (k)
      4'd0:  return x & y;
      4'd1:  return x | y;
      4'd6:  return 32'(longint'(x) - longint'(y));
      4'd7:  return (sx < sy) ? 32'd1 : 32'd0;
      4'd12: return ~(x | y);
      default: return 32'(longint'(x) + longint'(y));
    endcase
  endfunction

  function automatic string req_tag(input logic [1:0] c, input logic [5:0] f);
    if (c == 2'd0) return "R1";
    if (c == 2'd1) return "R2";
    if (c == 2'd3) return "R7";
    case (f)
      6'd32, 6'd34: return "R3";
      6'd36, 6'd37: return "R4";
      6'd39: return "R5";
      6'd42: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic apply(input logic [1:0] c, input logic [5:0] f, input logic [31:0] x, input logic [31:0] y);
    logic [3:0]  ek;
    logic [31:0] er;
    string tag;
    @(negedge clk);
    op_class = c; funct = f; a = x; b = y;
    @(posedge clk);
    #1;
    ek  = ref_ctrl(c, f);
    er  = ref_result(ek, x, y);
    tag = req_tag(c, f);
    compared++;
    if (ctrl !== ek) begin
      mismatched++;
      $display("FAIL %s ctrl cls=%0d fn=%0d actual=%b expected=%b", tag, c, f, ctrl, ek);
    end
    compared++;
    if (result !== er) begin
      mismatched++;
      $display("FAIL %s result cls=%0d fn=%0d a=%h b=%h actual=%h expected=%h", tag, c, f, x, y, result, er);
    end
    compared++; // R8
    if (zero !== (er == 32'd0)) begin
      mismatched++;
      $display("FAIL R8 zero actual=%b expected=%b", zero, (er == 32'd0));
    end
  endtask

  initial begin
    op_class = 2'd0; funct = 6'd0; a = 32'd0; b = 32'd0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    #1;
    // initial state: all-zero inputs give add of zeros, R1 R8
    compared++;
    if (result !== 32'd0 || zero !== 1'b1 || ctrl !== 4'd2) begin
      mismatched++;
      $display("FAIL R1 idle actual=%h/%b/%b expected=0/1/0010", result, zero, ctrl);
    end

    // exhaustive class x funct with random operands
    for (int c = 0; c < 4; c++)
      for (int f = 0; f < 64; f++)
        for (int r = 0; r < 4; r++)
          apply(2'(c), 6'(f), $urandom, (r == 3) ? 32'd0 : $urandom);

    // R1 carry wrap
    apply(2'd0, 6'd42, 32'hFFFF_FFFF, 32'd1);
    // R2 equal operands give zero, and wrap below zero
    apply(2'd1, 6'd36, 32'h1234_5678, 32'h1234_5678);
    apply(2'd1, 6'd0, 32'd0, 32'd1);
    // R3
    apply(2'd2, 6'd34, 32'h8000_0000, 32'd1);
    apply(2'd2, 6'd32, 32'h7FFF_FFFF, 32'd1);
    // R4
    apply(2'd2, 6'd36, 32'hF0F0_F0F0, 32'h0F0F_0F0F);
    apply(2'd2, 6'd37, 32'hF0F0_0000, 32'h0000_0F0F);
    // R5
    apply(2'd2, 6'd39, 32'd0, 32'd0);
    apply(2'd2, 6'd39, 32'hFFFF_0000, 32'h0000_FFFF);
    // R6 signed comparisons across sign boundary
    apply(2'd2, 6'd42, 32'h8000_0000, 32'd1);
    apply(2'd2, 6'd42, 32'd1, 32'h8000_0000);
    apply(2'd2, 6'd42, 32'hFFFF_FFFF, 32'd0);
    apply(2'd2, 6'd42, 32'd5, 32'd5);
    apply(2'd2, 6'd42, 32'h7FFF_FFFF, 32'h8000_0000);
    apply(2'd2, 6'd42, 32'hFFFF_FFFE, 32'hFFFF_FFFF);
    // R7
    apply(2'd2, 6'd38, 32'd10, 32'd20);
    apply(2'd3, 6'd34, 32'd10, 32'd20);
    // R8 add to zero
    apply(2'd0, 6'd0, 32'h8000_0000, 32'h8000_0000);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule